// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller for up to 32 pins. Software reaches it through a plain synchronous register bus. The bus has a write strobe, a read strobe, a 3-bit word address, four byte enables and 32-bit data. A write takes effect on the clock edge where the strobe is high. A read returns its word on `bus_rdata` one clock after the read strobe. The bus has no back-pressure: every access completes in one cycle.

On the output side, each pin takes its value either from a software output register or from a per-pin auxiliary input. Software also sets an output-enable register, and the block drives its inverse on an active-low enable vector.

On the input side, the pins go through a synchroniser and are then latched into an input register. The latch happens either on every bus clock or only on a chosen edge of an external sampling clock.

Changes in the latched inputs can raise interrupts. Each pin has its own enable and its own polarity, rising or falling. A triggered pin sets a sticky status bit and a pending flag in the control register. One request line is driven while the global enable bit is set.

Top module: `gpio_ctrl_top`

## Requirements
- R1: Writing the output-enable register (word 2) makes `pin_oe_n` equal to the bitwise inverse of the written value from the next clock on.
- R2: Each bit of `pin_out` equals `aux_in` where the auxiliary-select register (word 5) bit is 1, and the output register (word 1) bit where it is 0.
- R3: With control bit 0 (external-clock mode) clear, the input register (word 0) reads the pin value once the pins have been steady for two bus clocks.
- R4: With control bit 0 set, the input register changes only on a selected edge of the synchronised `ext_clk`. Changing the pins without such an edge leaves the read value unchanged.
- R5: With control bit 0 set, control bit 1 picks the capture edge: 0 captures on the rising edge of `ext_clk`, 1 captures on the falling edge.
- R6: A pin triggers when its interrupt-enable bit (word 3) is set and its latched input changes in the direction given by its polarity bit (word 4): 1 means low-to-high, 0 means high-to-low.
- R7: `irq` is high only while control bit 2 (global enable) is set and an interrupt is pending. A write of zero to the control register (word 6) drops `irq` on the next clock.
- R8: The status register (word 7) sets one bit per triggered pin. Each bit stays set, even after the global enable is cleared, until software overwrites it. A write of zero clears it.
- R9: With the inputs held steady, no status bit is set and `irq` stays low.
- R10: The input register ignores bus writes.
- R11: Control bit 3 reads 1 after a trigger while the global enable is set. A write of 0 to that bit clears it.
- R12: Byte enable k gates write data bits 8k+7..8k. Bytes whose enable is low keep their old value.
- R13: After reset every register reads zero, `pin_oe_n` is all ones and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NPINS | Pin input levels |
| aux_in | input | NPINS | Alternative output sources |
| ext_clk | input | 1 | External sampling clock, asynchronous |
| pin_out | output | NPINS | Pin output levels |
| pin_oe_n | output | NPINS | Active-low output enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch four behaviours on every cycle:
- the enable vector follows each full-width write to the output-enable word;
- the request drops after the control word is cleared;
- the input register is frozen between capture edges in external-clock mode;
- status bits neither fall without a write nor rise while the latched inputs are steady.

The edge-polarity choice, the auxiliary output selection, the read-only input word, the byte-lane masking and the end-to-end interrupt sequences depend on multi-step register programming. Only the bench's scenarios show those.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int BUS_DW = 32;
  localparam int BUS_AW = 3;
  localparam int BUS_BW = BUS_DW / 8;

  typedef enum logic [BUS_AW-1:0] {
    RA_IN   = 3'd0,
    RA_OUT  = 3'd1,
    RA_OE   = 3'd2,
    RA_IEN  = 3'd3,
    RA_POL  = 3'd4,
    RA_AUX  = 3'd5,
    RA_CTL  = 3'd6,
    RA_STAT = 3'd7
  } reg_addr_e;

  localparam int CB_ECLK = 0;
  localparam int CB_NEG  = 1;
  localparam int CB_GEN  = 2;
  localparam int CB_PEND = 3;

  function automatic logic [BUS_DW-1:0] merge_be(
    input logic [BUS_DW-1:0] old_w,
    input logic [BUS_DW-1:0] new_w,
    input logic [BUS_BW-1:0] be
  );
    logic [BUS_DW-1:0] r;
    r = old_w;
    for (int b = 0; b < BUS_BW; b++) begin
      if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_in_sampler.sv
module gpio_in_sampler #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic             ext_clk,
  input  logic             use_eclk,
  input  logic             neg_edge,
  output logic [NPINS-1:0] in_q,
  output logic             cap_edge
);
  logic [NPINS-1:0] pin_s;
  logic ek1, ek2, ek3;

  always_comb cap_edge = neg_edge ? (ek3 & ~ek2) : (ek2 & ~ek3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s <= '0;
      ek1   <= 1'b0;
      ek2   <= 1'b0;
      ek3   <= 1'b0;
      in_q  <= '0;
    end else begin
      pin_s <= pins;
      ek1   <= ext_clk;
      ek2   <= ek1;
      ek3   <= ek2;
      if (!use_eclk || cap_edge) in_q <= pin_s;
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] in_q,
  input  logic [NPINS-1:0] ien,
  input  logic [NPINS-1:0] pol,
  input  logic             glob_en,
  input  logic             stat_wr,
  input  logic [NPINS-1:0] stat_wval,
  input  logic             ctl_wr,
  input  logic             pend_wval,
  output logic [NPINS-1:0] stat_q,
  output logic             pend_q,
  output logic             irq
);
  logic [NPINS-1:0] in_prev;
  logic [NPINS-1:0] trig;

  always_comb begin
    trig = ien & ((pol & in_q & ~in_prev) | (~pol & ~in_q & in_prev));
    irq  = glob_en & pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prev <= '0;
      stat_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      in_prev <= in_q;
      stat_q  <= (stat_wr ? stat_wval : stat_q) | trig;
      pend_q  <= (ctl_wr ? pend_wval : pend_q) | (glob_en & (|trig));
    end
  end
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] aux_sel,
  input  logic [NPINS-1:0] aux_in,
  input  logic [NPINS-1:0] oe_q,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe_n
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_out[i]  = aux_sel[i] ? aux_in[i] : out_q[i];
    assign pin_oe_n[i] = ~oe_q[i];
  end
endmodule

// File: rtl/gpio_ctrl_top.sv
module gpio_ctrl_top
  import gpio_ctrl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_BW-1:0]    bus_be,
  input  logic [BUS_DW-1:0]    bus_wdata,
  output logic [BUS_DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  input  logic [NPINS-1:0]     aux_in,
  input  logic                 ext_clk,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe_n,
  output logic                 irq
);
  logic [NPINS-1:0] out_q, oe_q, ien_q, pol_q, aux_q;
  logic             use_eclk, neg_edge, gen_q;
  logic [NPINS-1:0] in_q, stat_q;
  logic             pend_q, cap_edge;
  logic [BUS_DW-1:0] rd_word, wr_word;
  reg_addr_e        ra;

  always_comb begin
    ra = reg_addr_e'(bus_addr);
    unique case (ra)
      RA_IN:   rd_word = BUS_DW'(in_q);
      RA_OUT:  rd_word = BUS_DW'(out_q);
      RA_OE:   rd_word = BUS_DW'(oe_q);
      RA_IEN:  rd_word = BUS_DW'(ien_q);
      RA_POL:  rd_word = BUS_DW'(pol_q);
      RA_AUX:  rd_word = BUS_DW'(aux_q);
      RA_CTL:  rd_word = BUS_DW'({pend_q, gen_q, neg_edge, use_eclk});
      default: rd_word = BUS_DW'(stat_q);
    endcase
    wr_word = merge_be(rd_word, bus_wdata, bus_be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      oe_q      <= '0;
      ien_q     <= '0;
      pol_q     <= '0;
      aux_q     <= '0;
      use_eclk  <= 1'b0;
      neg_edge  <= 1'b0;
      gen_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      if (bus_wr) begin
        case (ra)
          RA_OUT: out_q <= wr_word[NPINS-1:0];
          RA_OE:  oe_q  <= wr_word[NPINS-1:0];
          RA_IEN: ien_q <= wr_word[NPINS-1:0];
          RA_POL: pol_q <= wr_word[NPINS-1:0];
          RA_AUX: aux_q <= wr_word[NPINS-1:0];
          RA_CTL: begin
            use_eclk <= wr_word[CB_ECLK];
            neg_edge <= wr_word[CB_NEG];
            gen_q    <= wr_word[CB_GEN];
          end
          default: ;
        endcase
      end
    end
  end

  gpio_in_sampler #(.NPINS(NPINS)) u_smp (
    .clk(clk), .rst_n(rst_n), .pins(pin_in), .ext_clk(ext_clk),
    .use_eclk(use_eclk), .neg_edge(neg_edge), .in_q(in_q), .cap_edge(cap_edge)
  );

  gpio_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .in_q(in_q), .ien(ien_q), .pol(pol_q),
    .glob_en(gen_q),
    .stat_wr(bus_wr && ra == RA_STAT), .stat_wval(wr_word[NPINS-1:0]),
    .ctl_wr(bus_wr && ra == RA_CTL), .pend_wval(wr_word[CB_PEND]),
    .stat_q(stat_q), .pend_q(pend_q), .irq(irq)
  );

  gpio_out_mux #(.NPINS(NPINS)) u_mux (
    .out_q(out_q), .aux_sel(aux_q), .aux_in(aux_in), .oe_q(oe_q),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n)
  );
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] pin_oe_n,
  input logic             irq,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] in_q,
  input logic             use_eclk,
  input logic             cap_edge
);
  logic stat_wr;
  assign stat_wr = bus_wr && bus_addr == 3'd7;

  p_oe_follows_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && bus_be == 4'hF) |=> (pin_oe_n == ~$past(bus_wdata[NPINS-1:0])));

  p_irq_off_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6 && bus_be[0] && !bus_wdata[2]) |=> !irq);

  p_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_eclk && !cap_edge) |=> $stable(in_q));

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q == $past(in_q) && !stat_wr) |=> $stable(stat_q));
endmodule

bind gpio_ctrl_top gpio_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .pin_oe_n(pin_oe_n), .irq(irq),
  .stat_q(stat_q), .in_q(in_q), .use_eclk(use_eclk), .cap_edge(cap_edge)
);

// File: tb/sim_gpio_ctrl_top.sv
module sim_gpio_ctrl_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0, aux_in = '0;
  logic        ext_clk = 0;
  logic [31:0] pin_out, pin_oe_n;
  logic        irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl_top #(.NPINS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .aux_in(aux_in),
    .ext_clk(ext_clk), .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
  );

  // {aux_in, aux select, out register, expected pin_out}
  localparam logic [127:0] VEC [6] = '{
    {32'h00000000, 32'h00000000, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'h0000FFFF, 32'h00000000, 32'h0000FFFF},
    {32'h00000000, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFF0000},
    {32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0F0F, 32'hF00FF00F},
    {32'h12345678, 32'hFFFFFFFF, 32'h87654321, 32'h12345678}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rst_n = 1;
    idle(1);
    // R13 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R13 reset register", v, 32'h0);
    end
    chk("R13 reset oe_n", pin_oe_n, 32'hFFFFFFFF);
    chk("R13 reset irq", {31'h0, irq}, 32'h0);

    // R1, R2 vector table
    for (int i = 0; i < 6; i++) begin
      aux_in = VEC[i][127:96];
      wr(3'd5, VEC[i][95:64]);
      wr(3'd1, VEC[i][63:32]);
      wr(3'd2, VEC[i][63:32]);
      chk("R2 output mux", pin_out, VEC[i][31:0]);
      chk("R1 oe inverse", pin_oe_n, ~VEC[i][63:32]);
    end
    aux_in = '0;
    wr(3'd5, 32'h0);

    // R10 input register ignores writes
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, v);
    chk("R10 IN read-only", v, 32'h0);

    // R12 byte enables
    wr(3'd1, 32'h0);
    wr(3'd1, 32'hFFFFFFFF, 4'b0010);
    rd(3'd1, v);
    chk("R12 byte lane", v, 32'h0000FF00);
    chk("R12 pin_out after lane write", pin_out, 32'h0000FF00);

    // R3 bus-clock sampling
    pin_in = 32'h3C3C5AA5;
    idle(2);
    rd(3'd0, v);
    chk("R3 bus-clock sample", v, 32'h3C3C5AA5);

    // R4 external rising edge
    wr(3'd6, 32'h1);
    pin_in = 32'h11112222;
    idle(2);
    ext_clk = 1;
    idle(5);
    rd(3'd0, v);
    chk("R4 capture on ext rise", v, 32'h11112222);
    pin_in = 32'h33334444;
    idle(5);
    rd(3'd0, v);
    chk("R4 hold without edge", v, 32'h11112222);
    ext_clk = 0;
    idle(5);
    rd(3'd0, v);
    chk("R5 fall ignored in rising mode", v, 32'h11112222);

    // R5 falling-edge mode
    wr(3'd6, 32'h3);
    pin_in = 32'h55556666;
    idle(2);
    ext_clk = 1;
    idle(5);
    rd(3'd0, v);
    chk("R5 rise ignored in falling mode", v, 32'h11112222);
    ext_clk = 0;
    idle(5);
    rd(3'd0, v);
    chk("R5 capture on ext fall", v, 32'h55556666);

    // R6/R7/R8/R9/R11 falling-trigger interrupt
    wr(3'd6, 32'h0);
    pin_in = 32'hFFFFFFFF;
    idle(4);
    wr(3'd7, 32'h0);
    wr(3'd4, 32'h0);
    wr(3'd6, 32'h4);
    wr(3'd3, 32'hFFFFFFFF);
    idle(4);
    chk("R9 no irq with steady inputs", {31'h0, irq}, 32'h0);
    rd(3'd7, v);
    chk("R9 no status with steady inputs", v, 32'h0);
    pin_in = 32'h0;
    idle(5);
    chk("R6 falling trigger irq", {31'h0, irq}, 32'h1);
    rd(3'd7, v);
    chk("R8 status records pins", v, 32'hFFFFFFFF);
    rd(3'd6, v);
    chk("R11 pending bit set", v, 32'hC);
    wr(3'd6, 32'h0);
    chk("R7 irq drops after control clear", {31'h0, irq}, 32'h0);
    rd(3'd7, v);
    chk("R8 status sticky", v, 32'hFFFFFFFF);
    wr(3'd7, 32'h0);
    rd(3'd7, v);
    chk("R8 status cleared by zero write", v, 32'h0);

    // R6 rising trigger with per-pin enable, R11 clear
    wr(3'd4, 32'h0000000F);
    wr(3'd3, 32'h0000000F);
    wr(3'd6, 32'h4);
    pin_in = 32'h000000F0;
    idle(5);
    chk("R6 disabled pins do not trigger", {31'h0, irq}, 32'h0);
    pin_in = 32'h000000FF;
    idle(5);
    chk("R6 rising trigger irq", {31'h0, irq}, 32'h1);
    rd(3'd7, v);
    chk("R6 rising status", v, 32'h0000000F);
    wr(3'd6, 32'h4);
    chk("R11 pending cleared drops irq", {31'h0, irq}, 32'h0);
    rd(3'd6, v);
    chk("R11 control after clear", v, 32'h4);
    wr(3'd7, 32'h0);
    pin_in = 32'h0;
    idle(5);
    chk("R6 opposite edge ignored", {31'h0, irq}, 32'h0);
    rd(3'd7, v);
    chk("R6 opposite edge no status", v, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule